// File: doc/BRIEF.md
# Collision Backoff Delay Timer

After a collision, a transmitting station waits a random whole number of slot times before it tries again. This block makes that draw and times the wait. A request comes with the number of the retransmission attempt. The block masks a free-running pseudo-random value down to a range that doubles with each attempt until it reaches ten bits. It then counts that many slots of `SLOT_BITS` bit times each, where one bit time is one pulse of `bit_tick`. When the count is spent, it raises `done` for one cycle.

An optional carrier-hold mode freezes the count while receive carrier is present. When carrier drops, counting continues from the point where it stopped. On a busy medium this lengthens the wait for colliding stations, so that other stations get a turn. With the mode bit clear, carrier has no effect on the timer.

Top module: `bkf_backoff_timer`

## Requirements
- R1: After a request that draws r > 0, `busy` is high and `done` is low until exactly r*SLOT_BITS counted `bit_tick` cycles have passed. `done` is then high for exactly one cycle and `busy` falls in that same cycle.
- R2: From the cycle after a request, `slot_draw` holds r. For attempt number n, r satisfies 0 <= r < 2^min(n,10).
- R3: With `susp_en` high, a `bit_tick` in a cycle where `rx_carrier` is high is not counted. The countdown keeps its progress and continues from there once carrier drops.
- R4: With `susp_en` low, `rx_carrier` has no effect on when `done` appears.
- R5: When r = 0, which is always the case for attempt 0, `done` is high in the cycle after the request and `busy` stays low.
- R6: A request that arrives while a countdown is running starts a fresh draw and countdown. The earlier countdown never produces a `done`.
- R7: The random source is a 16-bit maximal-length LFSR that advances every clock, starts from a non-zero seed and never reaches zero. Successive requests at the same attempt number therefore give draws that vary.
- R8: During and right after reset, `busy`, `done` and `slot_draw` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| req | input | 1 | Start a backoff for `attempt` |
| attempt | input | ATT_W | Retransmission attempt number n |
| susp_en | input | 1 | Enable carrier-hold counting mode |
| rx_carrier | input | 1 | Receive carrier sense |
| busy | output | 1 | Countdown in progress |
| done | output | 1 | One-cycle pulse at the end of the backoff |
| slot_draw | output | MAX_EXP | Slot count r of the latest draw |

## Verification
The properties assume that `req` is a single-cycle pulse, that `attempt` is valid in the cycle `req` is high, and that reset is held for at least one clock. The directed bench pulses `req` for exactly one cycle, drives every input on the falling edge, and never pulses `req` twice in a row. Because the checker does not model the carrier-hold window, the bench keeps carrier bursts inside the running countdown and compares the measured number of counted ticks against r*SLOT_BITS.

// File: rtl/bkf_pkg.sv
package bkf_pkg;

    localparam int LFSR_W  = 16;
    localparam int MAX_EXP = 10;
    localparam int ATT_W   = 5;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    typedef struct packed {
        logic               valid;
        logic [MAX_EXP-1:0] slots;
    } draw_t;

    // x^16 + x^14 + x^13 + x^11 + 1, Fibonacci form
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    // bit i is set when min(n, MAX_EXP) > i
    function automatic logic [MAX_EXP-1:0] range_mask(input logic [ATT_W-1:0] n);
        logic [MAX_EXP-1:0] m;
        for (int i = 0; i < MAX_EXP; i++) begin
            m[i] = (32'(n) > i);
        end
        return m;
    endfunction

endpackage

// File: rtl/bkf_lfsr.sv
module bkf_lfsr
    import bkf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [LFSR_W-1:0] state
);
    always_ff @(posedge clk) begin
        if (rst) state <= LFSR_SEED;
        else     state <= lfsr_step(state);
    end
endmodule

// File: rtl/bkf_draw.sv
module bkf_draw
    import bkf_pkg::*;
(
    input  logic              req,
    input  logic [LFSR_W-1:0] rnd,
    input  logic [ATT_W-1:0]  attempt,
    output draw_t             draw
);
    logic [MAX_EXP-1:0] folded;

    // fold every LFSR bit into the draw field
    always_comb begin
        folded = '0;
        for (int i = 0; i < LFSR_W; i++) begin
            folded[i % MAX_EXP] = folded[i % MAX_EXP] ^ rnd[i];
        end
    end

    always_comb begin
        draw.valid = req;
        draw.slots = folded & range_mask(attempt);
    end
endmodule

// File: rtl/bkf_slot_timer.sv
module bkf_slot_timer
    import bkf_pkg::*;
#(
    parameter int SLOT_BITS = 512
) (
    input  logic  clk,
    input  logic  rst,
    input  draw_t load,
    input  logic  bit_tick,
    input  logic  hold,
    output logic  busy,
    output logic  done
);
    localparam int BIT_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_BITS - 1);

    logic [BIT_W-1:0]   bit_cnt;
    logic [MAX_EXP-1:0] slots_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            done       <= 1'b0;
            bit_cnt    <= '0;
            slots_left <= '0;
        end else begin
            done <= 1'b0;
            if (load.valid) begin
                bit_cnt    <= '0;
                slots_left <= load.slots;
                if (load.slots == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    busy <= 1'b1;
                end
            end else if (busy && bit_tick && !hold) begin
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt    <= '0;
                    slots_left <= slots_left - 1'b1;
                    if (slots_left == MAX_EXP'(1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/bkf_backoff_timer.sv
module bkf_backoff_timer
    import bkf_pkg::*;
#(
    parameter int SLOT_BITS = 512
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_tick,
    input  logic               req,
    input  logic [ATT_W-1:0]   attempt,
    input  logic               susp_en,
    input  logic               rx_carrier,
    output logic               busy,
    output logic               done,
    output logic [MAX_EXP-1:0] slot_draw
);
    logic [LFSR_W-1:0] lfsr_state;
    draw_t             draw;
    logic              hold;

    assign hold = susp_en & rx_carrier;

    bkf_lfsr u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .state (lfsr_state)
    );

    bkf_draw u_draw (
        .req     (req),
        .rnd     (lfsr_state),
        .attempt (attempt),
        .draw    (draw)
    );

    bkf_slot_timer #(.SLOT_BITS(SLOT_BITS)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (draw),
        .bit_tick (bit_tick),
        .hold     (hold),
        .busy     (busy),
        .done     (done)
    );

    always_ff @(posedge clk) begin
        if (rst)             slot_draw <= '0;
        else if (draw.valid) slot_draw <= draw.slots;
    end
endmodule

// File: rtl/bkf_backoff_chk.sv
module bkf_backoff_chk
    import bkf_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req,
    input logic [ATT_W-1:0]   attempt,
    input logic               susp_en,
    input logic               rx_carrier,
    input logic               busy,
    input logic               done,
    input logic [MAX_EXP-1:0] slot_draw,
    input logic [LFSR_W-1:0]  lfsr_state
);
    function automatic int cap_exp(input logic [ATT_W-1:0] n);
        return (32'(n) > MAX_EXP) ? MAX_EXP : 32'(n);
    endfunction

    AST_DRAW_RANGE: assert property (@(posedge clk) disable iff (rst)
        req |=> ((32'(slot_draw) >> cap_exp($past(attempt))) == 0)) else $error("draw out of range"); // R2

    AST_ZERO_DRAW_DONE: assert property (@(posedge clk) disable iff (rst)
        req |=> (done == (slot_draw == '0))) else $error("done vs zero draw"); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (done && !req) |=> !done) else $error("done longer than one cycle"); // R1

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy) else $error("done while busy"); // R1

    AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(req) || $past(busy))) else $error("spurious done"); // R1

    AST_CARRIER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && susp_en && rx_carrier && !req) |=> (busy && !done)) else $error("count moved under carrier"); // R3

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst)
        lfsr_state != '0) else $error("lfsr stuck at zero"); // R7

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && slot_draw == '0)) else $error("reset state"); // R8
endmodule

bind bkf_backoff_timer bkf_backoff_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .attempt    (attempt),
    .susp_en    (susp_en),
    .rx_carrier (rx_carrier),
    .busy       (busy),
    .done       (done),
    .slot_draw  (slot_draw),
    .lfsr_state (lfsr_state)
);

// File: tb/sim_bkf_backoff_timer.sv
module sim_bkf_backoff_timer;
    import bkf_pkg::*;

    localparam int SLOT = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               bit_tick = 1'b0;
    logic               req = 1'b0;
    logic [ATT_W-1:0]   attempt = '0;
    logic               susp_en = 1'b0;
    logic               rx_carrier = 1'b0;
    logic               busy;
    logic               done;
    logic [MAX_EXP-1:0] slot_draw;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bkf_backoff_timer #(.SLOT_BITS(SLOT)) u0 (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .req(req), .attempt(attempt),
        .susp_en(susp_en), .rx_carrier(rx_carrier), .busy(busy), .done(done),
        .slot_draw(slot_draw)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one-cycle request; returns on the falling edge after the loading edge
    task automatic pulse_req(input int att);
        req = 1'b1; attempt = ATT_W'(att);
        @(negedge clk);
        req = 1'b0;
    endtask

    // Request, then count bit ticks the design should honour, until done.
    task automatic run_case(input string tag, input int att, input int tick_every,
                            input int car_start, input int car_len, input bit en);
        int counted, target, step, lim;
        bit hit;
        susp_en = en; rx_carrier = 1'b0; bit_tick = 1'b0;
        pulse_req(att);
        target = int'(slot_draw) * SLOT;
        lim = (att > 10) ? 1024 : (1 << att);
        chk(int'(slot_draw) < lim, {tag, " R2 range"}, int'(slot_draw), lim - 1);
        counted = 0; step = 0; hit = 0;
        while (!hit && step < 40000) begin
            if (done) begin
                hit = 1;
                chk(counted == target, {tag, " R1 done timing"}, counted, target);
            end else if (counted == target) begin
                chk(0, {tag, " R1 done missing"}, 0, 1);
                break;
            end else begin
                if (step == 0) chk(busy == 1'b1, {tag, " R1 busy"}, busy, 1);
                step++;
                bit_tick   = (step % tick_every) == 0;
                rx_carrier = (step > car_start) && (step <= car_start + car_len);
                if (bit_tick && !(en && rx_carrier)) counted++;
                @(negedge clk);
            end
        end
        if (hit) begin
            chk(busy == 1'b0, {tag, " R1 busy low at done"}, busy, 0);
            bit_tick = 1'b0; rx_carrier = 1'b0;
            @(negedge clk);
            chk(done == 1'b0, {tag, " R1 single pulse"}, done, 0);
        end
        bit_tick = 1'b0; rx_carrier = 1'b0;
    endtask

    task automatic t_reset;
        chk(busy == 0 && done == 0 && slot_draw == 0, "R8 reset state",
            {busy, done}, 0);
    endtask

    task automatic t_zero;
        pulse_req(0);
        chk(done == 1'b1, "R5 done next cycle", done, 1);
        chk(busy == 1'b0, "R5 busy stays low", busy, 0);
        chk(slot_draw == 0, "R5 draw zero", slot_draw, 0);
        @(negedge clk);
        chk(done == 1'b0, "R5 pulse ends", done, 0);
    endtask

    task automatic t_reload;
        int first, quiet;
        bit_tick = 1'b1; susp_en = 1'b0;
        pulse_req(10);
        first = int'(slot_draw);
        quiet = 1;
        for (int i = 0; i < 5; i++) begin
            if (done) quiet = 0;
            @(negedge clk);
        end
        if (first != 0) chk(quiet == 1, "R6 no early done", quiet, 1);
        run_case("R6 reload", 3, 1, 0, 0, 0);
        quiet = 1;
        bit_tick = 1'b1;
        for (int i = 0; i < 3 * SLOT * 1024; i++) begin
            if (done) quiet = 0;
            @(negedge clk);
            if (i > 40) break;
        end
        bit_tick = 1'b0;
        chk(quiet == 1, "R6 old countdown silent", quiet, 1);
    endtask

    task automatic t_variety;
        int d0, diff;
        diff = 0;
        pulse_req(10); d0 = int'(slot_draw);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            pulse_req(10);
            if (int'(slot_draw) != d0) diff = 1;
        end
        chk(diff == 1, "R7 draws vary", diff, 1);
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(20 * 190000);
        chk(0, "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_zero();
        run_case("R1 att1",      1, 1, 0, 0, 0);
        run_case("R1 att4",      4, 1, 0, 0, 0);
        run_case("R1 sparse",    6, 3, 0, 0, 0);
        run_case("R2 trunc",    15, 1, 0, 0, 0);
        run_case("R2 att10",    10, 1, 0, 0, 0);
        run_case("R3 hold",      7, 1, 2, 20, 1);
        run_case("R3 hold2",     9, 2, 5, 37, 1);
        run_case("R4 ignore",    7, 1, 2, 20, 0);
        run_case("R4 ignore2",   5, 1, 0, 100, 0);
        t_reload();
        t_variety();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule